// File: doc/BRIEF.md
# March and Checkerboard Memory Self-Test Controller

This controller exercises a single-port memory array through its write and read strobes and reports every cell that reads back wrong. After a start pulse it runs a four-element march: zeros are written, then read back and replaced by ones, and the array is finally checked for zeros. After the march comes a checkerboard test that is applied twice, once with the pattern and once with its inverse. Each word read back is compared with the value the sequence last wrote there. On a mismatch the controller emits a fault record carrying the failing address. The records go out in read order to a downstream redundancy analyser, which can slow the flow through a ready input. No record is ever dropped.

The array is organised as `2**ROW_BITS` rows by `2**COL_BITS` columns of `DW`-bit words. The word address is `{row, col}`. The memory is expected to return read data on its data output one cycle after a read strobe.

The controller is a five-state machine:
- `ST_IDLE`: waits for `start`. `start` causes IDLE→WRITE.
- `ST_WRITE`: issues one write.
- `ST_READ`: issues one read. READ→CHECK always follows.
- `ST_CHECK`: compares the returned word. On a mismatch with `flt_ready` low it stays in CHECK. Otherwise it goes to WRITE for read-then-write elements, or it advances.
- `ST_DONE`: pulses `done`. DONE→IDLE always follows.

The advance step moves the address one place in the current element's direction and enters READ or WRITE. At the end of an element it loads the next element's starting address instead. After the final element it enters DONE.

There are eight elements, run in this order:
1. W0↑
2. R0W1↑
3. R1W0↓
4. R0↓
5. Wcb↑
6. Rcb↑
7. W~cb↑
8. R~cb↑

Top module: `mbist_ctrl`

## Requirements
- R1: While reset is asserted and afterwards until `start`, `busy`, `done`, `flt_valid`, `mem_we` and `mem_re` are all low.
- R2: A `start` seen in idle raises `busy` on the next cycle, and the first memory operation is a write of all-zero data to address 0.
- R3: The march writes and reads in this order: write 0 ascending; per address read 0 then write 1 ascending; per address read 1 then write 0 descending (from the top address down to 0); read 0 descending. Here "0" is the all-zero word and "1" the all-one word.
- R4: The checkerboard word at address `{row,col}` has bit i equal to `row[0] ^ col[0] ^ i[0]`. It is written ascending and then read ascending. The same two passes follow with every bit inverted, so after a run every cell holds the inverted checkerboard.
- R5: Every word read is compared with the expected pattern. A difference in any bit raises `flt_valid` with `flt_addr` equal to that read's address. Records appear in the order of the reads.
- R6: While `flt_valid` is high and `flt_ready` is low, `flt_valid` and `flt_addr` hold and no memory operation is issued. A record is consumed on a cycle where both are high.
- R7: `done` is high for exactly one cycle, the cycle after the last compare of the final read pass, with `busy` low. `busy` stays high for `15 * 2**(ROW_BITS+COL_BITS)` cycles plus one per stalled cycle.
- R8: `start` has no effect while the test is running.
- R9: At most one of `mem_we`/`mem_re` is high in a cycle. A read strobe is followed by a cycle with no strobe, in which `mem_rdata` is compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a test run |
| busy | output | 1 | Test sequence in progress |
| done | output | 1 | One-cycle end-of-test pulse |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | ROW_BITS+COL_BITS | Memory word address `{row,col}` |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after `mem_re` |
| flt_valid | output | 1 | Fault record available |
| flt_ready | input | 1 | Analyser accepts the fault record |
| flt_addr | output | ROW_BITS+COL_BITS | Address of the failing word |

## Verification
The sequence is run against a fault-free array, which shows that the write and read order and data are correct for every element. It is then run against arrays with stuck-at-1 and stuck-at-0 bits, including a word with one bit of each kind. These separate the march elements by which polarity they catch. They also show that exactly one of the two checkerboard passes reports each stuck bit. A second array with a stuck bit in every word floods the record stream. Under a toggling ready, stalls are exercised, and the bench checks that no record is lost or reordered and that the run lengthens by exactly the stalled cycles. A run with a second `start` mid-test must match the clean run cycle for cycle.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_CHECK,
        ST_DONE
    } state_e;

    // Test elements in execution order
    typedef enum logic [2:0] {
        EL_W0_UP,
        EL_R0W1_UP,
        EL_R1W0_DN,
        EL_R0_DN,
        EL_WCB_UP,
        EL_RCB_UP,
        EL_WICB_UP,
        EL_RICB_UP
    } elem_e;

    localparam elem_e EL_FINAL = EL_RICB_UP;

    typedef enum logic [1:0] {
        PAT_ZERO,
        PAT_ONE,
        PAT_CB,
        PAT_ICB
    } pat_e;

    function automatic logic elem_reads(input elem_e e);
        logic r;
        unique case (e)
            EL_W0_UP, EL_WCB_UP, EL_WICB_UP: r = 1'b0;
            default:                         r = 1'b1;
        endcase
        return r;
    endfunction

    function automatic logic elem_writes(input elem_e e);
        logic w;
        unique case (e)
            EL_R0_DN, EL_RCB_UP, EL_RICB_UP: w = 1'b0;
            default:                         w = 1'b1;
        endcase
        return w;
    endfunction

    function automatic logic elem_down(input elem_e e);
        return (e == EL_R1W0_DN) || (e == EL_R0_DN);
    endfunction

    function automatic pat_e elem_rd_pat(input elem_e e);
        pat_e p;
        unique case (e)
            EL_R1W0_DN: p = PAT_ONE;
            EL_RCB_UP:  p = PAT_CB;
            EL_RICB_UP: p = PAT_ICB;
            default:    p = PAT_ZERO;
        endcase
        return p;
    endfunction

    function automatic pat_e elem_wr_pat(input elem_e e);
        pat_e p;
        unique case (e)
            EL_R0W1_UP: p = PAT_ONE;
            EL_WCB_UP:  p = PAT_CB;
            EL_WICB_UP: p = PAT_ICB;
            default:    p = PAT_ZERO;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          load_down,
    input  logic          step,
    input  logic          down,
    output logic [AW-1:0] addr,
    output logic          last
);
    localparam logic [AW-1:0] ADDR_TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_down ? ADDR_TOP : '0;
        end else if (step) begin
            addr <= down ? (addr - 1'b1) : (addr + 1'b1);
        end
    end

    assign last = down ? (addr == '0) : (addr == ADDR_TOP);

endmodule

// File: rtl/mbist_pattern.sv
module mbist_pattern
    import mbist_pkg::*;
#(
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 3,
    parameter int DW       = 8,
    localparam int AW      = ROW_BITS + COL_BITS
) (
    input  logic [AW-1:0] addr,
    input  pat_e          kind,
    output logic [DW-1:0] data
);
    logic          cell_par;
    logic [DW-1:0] cb_word;

    // row lsb sits just above the column field
    assign cell_par = addr[0] ^ addr[COL_BITS];

    for (genvar i = 0; i < DW; i++) begin : g_cb_bit
        assign cb_word[i] = cell_par ^ ((i % 2) == 1);
    end

    always_comb begin
        unique case (kind)
            PAT_ZERO: data = '0;
            PAT_ONE:  data = '1;
            PAT_CB:   data = cb_word;
            PAT_ICB:  data = ~cb_word;
            default:  data = '0;
        endcase
    end

endmodule

// File: rtl/mbist_compare.sv
module mbist_compare #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] rdata,
    input  logic [DW-1:0] expect_data,
    output logic          mismatch
);
    assign mismatch = |(rdata ^ expect_data);
endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
    import mbist_pkg::*;
#(
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 3,
    parameter int DW       = 8,
    localparam int AW      = ROW_BITS + COL_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          mem_we,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          flt_valid,
    input  logic          flt_ready,
    output logic [AW-1:0] flt_addr
);
    state_e        state_q, state_d;
    elem_e         elem_q, elem_d, elem_nx;
    logic          ag_load, ag_load_down, ag_step, ag_last, adv;
    logic [AW-1:0] cur_addr;
    pat_e          pat_sel;
    logic [DW-1:0] pat_data;
    logic          mismatch;

    mbist_addr_gen #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ag_load),
        .load_down (ag_load_down),
        .step      (ag_step),
        .down      (elem_down(elem_q)),
        .addr      (cur_addr),
        .last      (ag_last)
    );

    mbist_pattern #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DW(DW)) u_pat (
        .addr (cur_addr),
        .kind (pat_sel),
        .data (pat_data)
    );

    mbist_compare #(.DW(DW)) u_cmp (
        .rdata       (mem_rdata),
        .expect_data (pat_data),
        .mismatch    (mismatch)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            elem_q  <= EL_W0_UP;
        end else begin
            state_q <= state_d;
            elem_q  <= elem_d;
        end
    end

    // Next state and sequencing
    always_comb begin
        state_d      = state_q;
        elem_d       = elem_q;
        elem_nx      = elem_e'(elem_q + 3'd1);
        ag_load      = 1'b0;
        ag_load_down = 1'b0;
        ag_step      = 1'b0;
        adv          = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_WRITE;
                    elem_d  = EL_W0_UP;
                    ag_load = 1'b1;
                end
            end
            ST_WRITE: adv = 1'b1;
            ST_READ:  state_d = ST_CHECK;
            ST_CHECK: begin
                if (!(mismatch && !flt_ready)) begin
                    if (elem_writes(elem_q)) state_d = ST_WRITE;
                    else                     adv     = 1'b1;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase

        if (adv) begin
            if (!ag_last) begin
                ag_step = 1'b1;
                state_d = elem_reads(elem_q) ? ST_READ : ST_WRITE;
            end else if (elem_q == EL_FINAL) begin
                state_d = ST_DONE;
            end else begin
                elem_d       = elem_nx;
                ag_load      = 1'b1;
                ag_load_down = elem_down(elem_nx);
                state_d      = elem_reads(elem_nx) ? ST_READ : ST_WRITE;
            end
        end
    end

    // Outputs
    always_comb begin
        pat_sel   = (state_q == ST_WRITE) ? elem_wr_pat(elem_q) : elem_rd_pat(elem_q);
        mem_we    = (state_q == ST_WRITE);
        mem_re    = (state_q == ST_READ);
        mem_addr  = cur_addr;
        mem_wdata = pat_data;
        flt_valid = (state_q == ST_CHECK) && mismatch;
        flt_addr  = cur_addr;
        busy      = (state_q == ST_WRITE) || (state_q == ST_READ) || (state_q == ST_CHECK);
        done      = (state_q == ST_DONE);
    end

endmodule

// File: rtl/mbist_ctrl_chk.sv
module mbist_ctrl_chk #(
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          mem_we,
    input logic          mem_re,
    input logic          flt_valid,
    input logic          flt_ready,
    input logic [AW-1:0] flt_addr
);
    a_r9_single_op: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    a_r9_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (!mem_re && !mem_we));

    a_r6_record_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && !flt_ready) |=> (flt_valid && $stable(flt_addr)));

    a_r6_no_op_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && !flt_ready) |-> (!mem_we && !mem_re));

    a_r5_fault_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> busy);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r7_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> busy);

endmodule

bind mbist_ctrl mbist_ctrl_chk #(.AW(AW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .flt_valid (flt_valid),
    .flt_ready (flt_ready),
    .flt_addr  (flt_addr)
);

// File: tb/test_mbist_ctrl.sv
module test_mbist_ctrl;
    localparam int RB   = 3;
    localparam int COLB = 2;
    localparam int DW   = 4;
    localparam int AW   = RB + COLB;
    localparam int N    = 1 << AW;
    localparam int NOPS = 5 * N;

    // element table: reads, writes, descending, read kind, write kind
    localparam int E_RD[8] = '{0, 1, 1, 1, 0, 1, 0, 1};
    localparam int E_WR[8] = '{1, 1, 1, 0, 1, 0, 1, 0};
    localparam int E_DN[8] = '{0, 0, 1, 1, 0, 0, 0, 0};
    localparam int E_RK[8] = '{0, 0, 1, 0, 0, 2, 0, 3};
    localparam int E_WK[8] = '{0, 1, 0, 0, 2, 0, 3, 0};

    logic          clk, rst_n, start, busy, done, mem_we, mem_re;
    logic          flt_valid, flt_ready;
    logic [AW-1:0] mem_addr, flt_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    mbist_ctrl #(.ROW_BITS(RB), .COL_BITS(COLB), .DW(DW)) i_mbist_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .flt_valid(flt_valid), .flt_ready(flt_ready), .flt_addr(flt_addr)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // memory model with stuck-at bits applied on read
    logic [DW-1:0] mem      [N];
    logic [DW-1:0] stk_mask [N];
    logic [DW-1:0] stk_val  [N];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= (mem[mem_addr] & ~stk_mask[mem_addr])
                               | (stk_val[mem_addr] & stk_mask[mem_addr]);
    end

    int n_vec = 0, n_bad = 0;
    int ex_wa [NOPS];
    int ex_wd [NOPS];
    int ex_we [NOPS];
    int ex_ra [NOPS];
    int ex_re [NOPS];
    int ex_fl [NOPS];
    int nw, nr, nf, widx, ridx, fidx;
    int busy_cnt, done_cnt, stall_cnt;
    bit mon_en = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int k, input int a);
        logic [AW-1:0] av;
        logic          c;
        logic [DW-1:0] v;
        av = AW'(a);
        c  = av[0] ^ av[COLB];
        for (int i = 0; i < DW; i++) v[i] = c ^ (i % 2 == 1);
        case (k)
            0:       return '0;
            1:       return '1;
            2:       return v;
            default: return ~v;
        endcase
    endfunction

    function automatic string etag(input int e);
        return (e < 4) ? "R3" : "R4";
    endfunction

    task automatic build_expect();
        int a;
        nw = 0; nr = 0; nf = 0;
        for (int e = 0; e < 8; e++) begin
            for (int j = 0; j < N; j++) begin
                a = (E_DN[e] != 0) ? (N - 1 - j) : j;
                if (E_RD[e] != 0) begin
                    ex_ra[nr] = a; ex_re[nr] = e; nr++;
                    if (((pat(E_RK[e], a) ^ stk_val[a]) & stk_mask[a]) != '0) begin
                        ex_fl[nf] = a; nf++;
                    end
                end
                if (E_WR[e] != 0) begin
                    ex_wa[nw] = a; ex_wd[nw] = int'(pat(E_WK[e], a)); ex_we[nw] = e; nw++;
                end
            end
        end
    endtask

    task automatic clear_faults();
        for (int a = 0; a < N; a++) begin
            stk_mask[a] = '0; stk_val[a] = '0;
        end
    endtask

    // monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (mon_en) begin
            chk(!(mem_we && mem_re), "R9 single strobe", int'(mem_we), 0);
            if (busy) busy_cnt++;
            if (done) begin
                done_cnt++;
                chk(!busy, "R7 busy low with done", int'(busy), 0);
            end
            if (mem_we) begin
                if (widx < nw) begin
                    chk(int'(mem_addr) == ex_wa[widx],
                        (widx == 0) ? "R2 first write addr" : etag(ex_we[widx]),
                        int'(mem_addr), ex_wa[widx]);
                    chk(int'(mem_wdata) == ex_wd[widx],
                        (widx == 0) ? "R2 first write data" : etag(ex_we[widx]),
                        int'(mem_wdata), ex_wd[widx]);
                end else chk(1'b0, "R3 extra write", widx, nw);
                widx++;
            end
            if (mem_re) begin
                if (ridx < nr)
                    chk(int'(mem_addr) == ex_ra[ridx], etag(ex_re[ridx]),
                        int'(mem_addr), ex_ra[ridx]);
                else chk(1'b0, "R3 extra read", ridx, nr);
                ridx++;
            end
            if (flt_valid) begin
                if (flt_ready) begin
                    if (fidx < nf)
                        chk(int'(flt_addr) == ex_fl[fidx], "R5 fault address",
                            int'(flt_addr), ex_fl[fidx]);
                    else chk(1'b0, "R5 extra fault record", int'(flt_addr), -1);
                    fidx++;
                end else begin
                    stall_cnt++;
                    chk(!mem_we && !mem_re, "R6 no op while stalled", int'(mem_we | mem_re), 0);
                end
            end
        end
    end

    // ready_mode: 0 always ready, 1 toggling; restart: pulse start mid-run
    task automatic run(input string name, input int ready_mode, input bit restart);
        int cyc;
        build_expect();
        widx = 0; ridx = 0; fidx = 0;
        busy_cnt = 0; done_cnt = 0; stall_cnt = 0;
        mon_en = 1'b1;
        @(posedge clk); #1 start = 1'b1; flt_ready = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        cyc = 0;
        while (done_cnt == 0) begin
            @(posedge clk); #1;
            cyc++;
            flt_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
            start = restart && (cyc == 100 || cyc == 101);
            if (cyc > 20000) begin
                chk(1'b0, "R7 watchdog expired", cyc, 15 * N);
                break;
            end
        end
        start = 1'b0; flt_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        mon_en = 1'b0;
        $display("run %s: %0d records, %0d stall cycles", name, fidx, stall_cnt);
        chk(busy_cnt == 15 * N + stall_cnt, restart ? "R8 run length with restart" : "R7 busy length",
            busy_cnt, 15 * N + stall_cnt);
        chk(done_cnt == 1, "R7 single done pulse", done_cnt, 1);
        chk(widx == nw, "R3 write count", widx, nw);
        chk(ridx == nr, "R9 read count", ridx, nr);
        chk(fidx == nf, "R5 fault record count", fidx, nf);
        if (ready_mode != 0 && nf > 0) chk(stall_cnt > 0, "R6 stalls exercised", stall_cnt, 1);
        for (int a = 0; a < N; a++)
            chk(mem[a] == pat(3, a), "R4 final inverted checkerboard", int'(mem[a]), int'(pat(3, a)));
        chk(!busy && !done && !flt_valid, "R1 idle after run", int'(busy), 0);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; flt_ready = 1'b1; mem_rdata = '0;
        for (int a = 0; a < N; a++) mem[a] = '0;
        clear_faults();
        repeat (3) @(negedge clk);
        chk({busy, done, flt_valid, mem_we, mem_re} == 5'b0, "R1 outputs in reset",
            int'({busy, done, flt_valid, mem_we, mem_re}), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({busy, done, flt_valid, mem_we, mem_re} == 5'b0, "R1 outputs idle after reset",
            int'({busy, done, flt_valid, mem_we, mem_re}), 0);

        run("clean", 0, 1'b0);

        stk_mask[0]  = 4'b0001; stk_val[0]  = 4'b0001;
        stk_mask[31] = 4'b1000; stk_val[31] = 4'b0000;
        stk_mask[9]  = 4'b0110; stk_val[9]  = 4'b0100;
        stk_mask[18] = 4'b0100; stk_val[18] = 4'b0100;
        stk_mask[6]  = 4'b0010; stk_val[6]  = 4'b0000;
        run("stuck", 0, 1'b0);
        run("stuck_stall", 1, 1'b0);

        clear_faults();
        run("restart", 0, 1'b1);

        for (int a = 0; a < N; a++) begin
            stk_mask[a] = 4'b0010; stk_val[a] = '0;
        end
        run("flood_stall", 1, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule